// File: doc/BRIEF.md
# Memory bit test unit

This unit carries out one instruction: test a single bit of a byte held in memory and report the result in the zero flag. The instruction comes in one of two encodings. In the displacement form, the byte address is a base register plus a sign-extended 16-bit displacement, and the bit number is a 3-bit immediate. In the register form, the byte address is the base register alone, and a second register supplies the bit number.

A start pulse hands the unit both instruction halfwords. The unit then names the registers it needs on two register-file index outputs and forms the address. It issues a byte read on a request/ready port and waits through any number of wait states. When the byte arrives, it sets Z to the inverse of the selected bit. It writes no register and no memory location, and it drives no flag other than Z.

A read with no wait states completes in three clocks. These are a decode cycle, one request cycle and a finish cycle in which `done_o` pulses. Each wait state adds one request cycle.

Top module: `mbt_unit`

## Requirements
- R1: The displacement form is recognised when first-halfword bits 15:14 are 11 and bits 10:5 are 111110. Bits 13:11 give the bit number and bits 4:0 the base register. The second halfword is a displacement that is sign-extended and added to the base value. The sum wraps modulo 2^ADDR_W.
- R2: The register form is recognised when first-halfword bits 10:5 are 111111 and the second halfword is 0x00E6. The address is the base register value. The bit number is bits 2:0 of the register indexed by first-halfword bits 15:11.
- R3: When a read completes, `z_o` becomes the logical inverse of bit n of the returned byte, where n is the bit number (bit 0 = LSB).
- R4: With `mem_ready_i` high in the first request cycle, `done_o` is high in the third cycle after the cycle in which an accepted `start_i` was high.
- R5: Each cycle in which `mem_req_o` is high and `mem_ready_i` is low adds one cycle of latency. During that time `mem_req_o` and `mem_addr_o` stay unchanged.
- R6: The byte on `mem_rdata_i` is taken in the same cycle that `mem_ready_i` is high. `mem_req_o` is low in the cycle after that.
- R7: A start with an encoding that matches neither form is ignored: no request, no done, and Z keeps its value. A start while the unit is busy is also ignored.
- R8: `done_o` is a one-cycle pulse. `z_o` changes only in a cycle in which `done_o` is high. After reset, `z_o`, `done_o`, `busy_o` and `mem_req_o` are 0.
- R9: In the cycle after an accepted start, `rf_base_idx_o` equals first-halfword bits 4:0. In the register form, `rf_bit_idx_o` equals first-halfword bits 15:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse with the instruction halfwords |
| insn_hw0_i | input | 16 | First instruction halfword |
| insn_hw1_i | input | 16 | Second instruction halfword |
| busy_o | output | 1 | An instruction is in progress |
| rf_base_idx_o | output | 5 | Register-file index of the base register |
| rf_bit_idx_o | output | 5 | Register-file index of the bit-number register |
| rf_base_data_i | input | ADDR_W | Value of the base register |
| rf_bit_low_i | input | 3 | Bits 2:0 of the bit-number register |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | ADDR_W | Byte read address |
| mem_ready_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 8 | Returned byte |
| done_o | output | 1 | Z updated this cycle |
| z_o | output | 1 | Zero flag |

## Verification
The bench attacks the address arithmetic with negative displacements that wrap below zero and through the top of the address space. An adder without sign extension would read a far-away byte. A bit-number register with high bits set catches a unit that uses more than bits 2:0, because such a unit would pick the wrong bit or none. Wait-state runs of several lengths, together with a second start injected mid-read, expose a request that drops early, an address that drifts, a miscounted latency, or a restarted operation. A sweep over all eight bit positions and a set of malformed encodings catch a flag that is not inverted, a wrong bit order, and a decoder that accepts near-miss opcodes.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_SEL_W = $clog2(BYTE_W);
    localparam int HW_W = 16;
    localparam int RIDX_W = 5;

    localparam logic [5:0]      OPC_DISP  = 6'b111110;
    localparam logic [5:0]      OPC_REG   = 6'b111111;
    localparam logic [1:0]      DISP_TAG  = 2'b11;
    localparam logic [HW_W-1:0] SUBOP_REG = 16'h00E6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEC  = 2'd1,
        ST_RD   = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    typedef enum logic {
        FORM_DISP = 1'b0,
        FORM_REG  = 1'b1
    } form_e;

    typedef struct packed {
        form_e                  form;
        logic [RIDX_W-1:0]      base_idx;
        logic [RIDX_W-1:0]      src_idx;
        logic [BIT_SEL_W-1:0]   imm_bit;
        logic [HW_W-1:0]        disp;
    } insn_t;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
(
    input  logic [HW_W-1:0] hw0_i,
    input  logic [HW_W-1:0] hw1_i,
    output logic            valid_o,
    output insn_t           insn_o
);
    logic is_disp;
    logic is_reg;

    always_comb begin
        is_disp = (hw0_i[15:14] == DISP_TAG) && (hw0_i[10:5] == OPC_DISP);
        is_reg  = (hw0_i[10:5] == OPC_REG) && (hw1_i == SUBOP_REG);
        valid_o = is_disp || is_reg;

        insn_o.form     = is_reg ? FORM_REG : FORM_DISP;
        insn_o.base_idx = hw0_i[4:0];
        insn_o.src_idx  = hw0_i[15:11];
        insn_o.imm_bit  = hw0_i[13:11];
        insn_o.disp     = is_reg ? '0 : hw1_i;
    end
endmodule

// File: rtl/mbt_agu.sv
module mbt_agu
    import mbt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  insn_t                 insn_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [BIT_SEL_W-1:0]  src_low_i,
    output logic [ADDR_W-1:0]     addr_o,
    output logic [BIT_SEL_W-1:0]  bitn_o
);
    logic [ADDR_W-1:0] disp_ext;

    generate
        if (ADDR_W > HW_W) begin : g_wide
            assign disp_ext = {{(ADDR_W-HW_W){insn_i.disp[HW_W-1]}}, insn_i.disp};
        end else begin : g_narrow
            assign disp_ext = insn_i.disp[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (insn_i.form == FORM_REG) begin
            addr_o = base_i;
            bitn_o = src_low_i;
        end else begin
            addr_o = base_i + disp_ext;
            bitn_o = insn_i.imm_bit;
        end
    end
endmodule

// File: rtl/mbt_bitsel.sv
module mbt_bitsel
    import mbt_pkg::*;
(
    input  logic [BYTE_W-1:0]    byte_i,
    input  logic [BIT_SEL_W-1:0] bitn_i,
    output logic                 bit_o
);
    logic [BYTE_W-1:0] hit;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign hit[i] = (bitn_i == BIT_SEL_W'(i)) && byte_i[i];
    end

    assign bit_o = |hit;
endmodule

// File: rtl/mbt_unit.sv
module mbt_unit
    import mbt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [15:0]          insn_hw0_i,
    input  logic [15:0]          insn_hw1_i,
    output logic                 busy_o,
    output logic [4:0]           rf_base_idx_o,
    output logic [4:0]           rf_bit_idx_o,
    input  logic [ADDR_W-1:0]    rf_base_data_i,
    input  logic [2:0]           rf_bit_low_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic                 mem_ready_i,
    input  logic [7:0]           mem_rdata_i,
    output logic                 done_o,
    output logic                 z_o
);
    typedef struct packed {
        state_e                 st;
        insn_t                  insn;
        logic [ADDR_W-1:0]      addr;
        logic [BIT_SEL_W-1:0]   bitn;
        logic                   z;
    } regs_t;

    regs_t r_d, r_q;

    logic                   dec_valid;
    insn_t                  dec_insn;
    logic [ADDR_W-1:0]      agu_addr;
    logic [BIT_SEL_W-1:0]   agu_bitn;
    logic                   sel_bit;

    mbt_decode u_decode (
        .hw0_i   (insn_hw0_i),
        .hw1_i   (insn_hw1_i),
        .valid_o (dec_valid),
        .insn_o  (dec_insn)
    );

    mbt_agu #(.ADDR_W(ADDR_W)) u_agu (
        .insn_i    (r_q.insn),
        .base_i    (rf_base_data_i),
        .src_low_i (rf_bit_low_i),
        .addr_o    (agu_addr),
        .bitn_o    (agu_bitn)
    );

    mbt_bitsel u_bitsel (
        .byte_i (mem_rdata_i),
        .bitn_i (r_q.bitn),
        .bit_o  (sel_bit)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i && dec_valid) begin
                    r_d.insn = dec_insn;
                    r_d.st   = ST_DEC;
                end
            end
            ST_DEC: begin
                r_d.addr = agu_addr;
                r_d.bitn = agu_bitn;
                r_d.st   = ST_RD;
            end
            ST_RD: begin
                if (mem_ready_i) begin
                    r_d.z  = ~sel_bit;
                    r_d.st = ST_FIN;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o        = (r_q.st != ST_IDLE);
    assign rf_base_idx_o = r_q.insn.base_idx;
    assign rf_bit_idx_o  = r_q.insn.src_idx;
    assign mem_req_o     = (r_q.st == ST_RD);
    assign mem_addr_o    = r_q.addr;
    assign done_o        = (r_q.st == ST_FIN);
    assign z_o           = r_q.z;

endmodule

// File: rtl/mbt_unit_chk.sv
module mbt_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ready_i,
    input logic              done_o,
    input logic              z_o
);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    p_ready_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i) |=> (done_o && !mem_req_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_z_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(z_o));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o));

    p_done_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);
endmodule

bind mbt_unit mbt_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .done_o      (done_o),
    .z_o         (z_o)
);

// File: tb/tb_mbt_unit.sv
module tb_mbt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] hw0 = '0, hw1 = '0;
    logic        busy, mem_req, mem_ready = 1'b0, done, z;
    logic [4:0]  base_idx, bit_idx;
    logic [31:0] mem_addr, base_data;
    logic [2:0]  bit_low;
    logic [7:0]  rdata;
    logic [31:0] regs [32];
    int          wait_cfg = 0, wcnt = 0;
    int          total = 0, bad = 0;
    bit          finished = 0;
    logic        last_z;

    always #5 clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
    endfunction
    function automatic logic [15:0] enc_disp(input logic [2:0] b, input logic [4:0] r1);
        return {2'b11, b, 6'b111110, r1};
    endfunction
    function automatic logic [15:0] enc_reg(input logic [4:0] r2, input logic [4:0] r1);
        return {r2, 6'b111111, r1};
    endfunction

    assign base_data = regs[base_idx];
    assign bit_low   = regs[bit_idx][2:0];
    assign rdata     = mbyte(mem_addr);

    mbt_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .insn_hw0_i(hw0), .insn_hw1_i(hw1),
        .busy_o(busy), .rf_base_idx_o(base_idx), .rf_bit_idx_o(bit_idx),
        .rf_base_data_i(base_data), .rf_bit_low_i(bit_low),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
        .mem_rdata_i(rdata), .done_o(done), .z_o(z)
    );

    always @(negedge clk) begin
        if (mem_req) begin
            mem_ready = (wcnt >= wait_cfg);
            wcnt++;
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] h0, input logic [15:0] h1, input int waits,
                          input logic [31:0] exp_addr, input logic [2:0] exp_bit,
                          input string req, input bit inject);
        int cyc;
        bit seen = 0, drift = 0;
        logic [31:0] a0 = '0;
        logic exp_z;
        @(negedge clk);
        wait_cfg = waits;
        hw0 = h0; hw1 = h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        // R9: indices in the decode cycle
        check(base_idx == h0[4:0], "R9", "base index", {27'd0, base_idx}, {27'd0, h0[4:0]});
        check(bit_idx == h0[15:11], "R9", "bit index", {27'd0, bit_idx}, {27'd0, h0[15:11]});
        while (!done && cyc < 60) begin
            if (mem_req) begin
                if (!seen) begin a0 = mem_addr; seen = 1; end
                else if (mem_addr != a0) drift = 1;
            end
            if (inject && cyc == 2) begin
                hw0 = enc_disp(3'd0, 5'd2); hw1 = 16'h0001; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        exp_z = ~mbyte(exp_addr)[exp_bit];
        check(cyc == 3 + waits, "R4/R5", "latency", cyc, 3 + waits);
        check(a0 == exp_addr, req, "address", a0, exp_addr);
        check(!drift, "R5", "address hold", {31'd0, drift}, 0);
        check(z == exp_z, "R3", "z flag", {31'd0, z}, {31'd0, exp_z});
        last_z = z;
        @(negedge clk);
        check(!done && !mem_req, "R8", "done pulse", {30'd0, done, mem_req}, 0);
        if (inject) begin
            for (int i = 0; i < 5; i++) begin
                check(!mem_req && !done, "R7", "busy start ignored", {30'd0, mem_req, done}, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic bad_op(input logic [15:0] h0, input logic [15:0] h1, input string what);
        @(negedge clk);
        hw0 = h0; hw1 = h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check(!mem_req && !done && !busy, "R7", what, {29'd0, mem_req, done, busy}, 0);
            check(z == last_z, "R7", "z kept", {31'd0, z}, {31'd0, last_z});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(!z && !done && !busy && !mem_req, "R8", "reset state",
              {28'd0, z, done, busy, mem_req}, 0);
        last_z = z;
    endtask

    task automatic t_disp();
        regs[3] = 32'h0000_2000;
        run_op(enc_disp(3'd5, 5'd3), 16'h0034, 0, 32'h2034, 3'd5, "R1", 0);
        regs[7] = 32'h0000_0010;
        run_op(enc_disp(3'd1, 5'd7), 16'hFFF0, 0, 32'h0000_0000, 3'd1, "R1", 0);
        regs[8] = 32'h0000_0004;
        run_op(enc_disp(3'd7, 5'd8), 16'hFFF8, 1, 32'hFFFF_FFFC, 3'd7, "R1", 0);
    endtask

    task automatic t_reg();
        regs[9]  = 32'h0001_0040;
        regs[12] = 32'hFFFF_FFFD;
        run_op(enc_reg(5'd12, 5'd9), 16'h00E6, 2, 32'h0001_0040, 3'd5, "R2", 0);
        run_op(enc_reg(5'd9, 5'd9), 16'h00E6, 0, 32'h0001_0040, 3'd0, "R2", 0);
        regs[13] = 32'h8000_0123;
        run_op(enc_reg(5'd12, 5'd13), 16'h00E6, 6, 32'h8000_0123, 3'd5, "R2", 0);
    endtask

    task automatic t_sweep();
        regs[2] = 32'h0000_0100;
        for (int b = 0; b < 8; b++)
            run_op(enc_disp(3'(b), 5'd2), 16'h0055, b % 3, 32'h0000_0155, 3'(b), "R3", 0);
    endtask

    task automatic t_bad();
        bad_op(16'h0000, 16'h0000, "zero encoding");
        bad_op(enc_reg(5'd12, 5'd9), 16'h00E7, "wrong sub-opcode");
        bad_op({2'b10, 3'd1, 6'b111110, 5'd1}, 16'h0000, "wrong tag");
    endtask

    task automatic t_busy();
        regs[4] = 32'h0000_3000;
        run_op(enc_disp(3'd2, 5'd4), 16'h0007, 4, 32'h3007, 3'd2, "R7", 1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_disp();
        t_reg();
        t_sweep();
        t_bad();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule